// File: doc/BRIEF.md
# Initialization Command List Sequencer

This block replays a list of initialization commands stored in a command ROM and turns each one into transfers on a simple register-bus master. A controller hands it an index range and pulses `start`. The block then fetches commands from the first index up to, but not including, the end index, one after another. For each command it emits single register writes, single reads, multi-word string writes, mailbox-path writes or bulk zero/copy transfers. Payload words for string and copy commands come from a separate data ROM.

Bulk transfers are marked out as chunks whose length never exceeds a parameterized maximum burst. Each beat carries its own byte address, so every chunk starts where the previous one ended. A bulk command whose word count exceeds the staging buffer limit is refused. An opcode outside the supported set is refused as well. Decompress-and-copy (opcode 7) is one of the refused opcodes. Each refusal sets a sticky error flag, and the sequencer moves on to the next command. `busy` and a one-cycle `done` pulse frame every run.

Top module: `init_cmd_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `bus_valid` are all low.
- R2: A start accepted while idle executes commands from `first_idx` up to `end_idx - 1` in increasing index order. A start with `first_idx >= end_idx` produces no bus beats and still gives a `done` pulse.
- R3: A command word is laid out as {opcode[3:0], address[ADDR_W], length[LEN_W], argument[DATA_W]}, with the argument in the least significant bits. Opcode 1 issues one beat of kind 0 (read) with data 0. Opcode 2 issues one beat of kind 1 (direct write) with data equal to the argument. Opcode 3 issues one beat of kind 2 (mailbox write) with data equal to the argument. The length field is ignored for all three.
- R4: Opcodes 4 and 5 issue `length` beats of kind 1 and kind 2 respectively. Beat i goes to address + 4*i and carries the data-ROM word at argument + i. A length of 0 produces no beats and no error.
- R5: Opcode 6 (zero fill) issues beats of kind 3 carrying zero. The number of beats is taken from the low LEN_W bits of the argument, and the length field is ignored. Beat i goes to address + 4*i.
- R6: Opcode 8 (bulk copy) issues `length` beats of kind 3. Beat i goes to address + 4*i and carries the data-ROM word at argument + i.
- R7: On kind-3 beats, `bus_chunk_first` is high when i mod MAX_BURST = 0. On the same beats, `bus_chunk_last` is high when i mod MAX_BURST = MAX_BURST-1 or when i is the command's last beat. Both markers are low on every other kind.
- R8: A bulk command (opcode 6 or 8) whose beat count exceeds BUF_WORDS issues no beats and sets `err`. A count equal to BUF_WORDS is executed.
- R9: Opcode 7, opcode 0 and opcodes 9 to 15 issue no beats and set `err`. Execution continues with the next command.
- R10: `err` stays set until the next start accepted while idle, which clears it.
- R11: `busy` is high from the cycle after an accepted non-empty start until `done`. `done` is high for exactly one cycle, with `busy` low in that cycle. A `start` while busy is ignored.
- R12: While `bus_valid` is high and `bus_ready` is low, the beat's valid, kind, address and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run over the given index range |
| first_idx | input | IDX_W | First command index, inclusive |
| end_idx | input | IDX_W | End command index, exclusive |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| err | output | 1 | Sticky error: refused or unknown command |
| cmd_addr | output | IDX_W | Command ROM address |
| cmd_rdata | input | 4+ADDR_W+LEN_W+DATA_W | Command ROM word, one cycle after address |
| dat_addr | output | DOFF_W | Data ROM address |
| dat_rdata | input | DATA_W | Data ROM word, one cycle after address |
| bus_valid | output | 1 | Bus beat offered |
| bus_ready | input | 1 | Bus beat accepted when high with valid |
| bus_kind | output | 2 | 0 read, 1 direct write, 2 mailbox write, 3 bulk write |
| bus_addr | output | ADDR_W | Byte address of the beat |
| bus_data | output | DATA_W | Beat data |
| bus_chunk_first | output | 1 | First beat of a bulk chunk |
| bus_chunk_last | output | 1 | Last beat of a bulk chunk |

## Verification
The bench builds the block with MAX_BURST = 4 and BUF_WORDS = 10, so a ten-word fill already splits into chunks of 4, 4 and 2. The same settings put both sides of the buffer limit (10 words accepted, 11 refused) within a few dozen cycles. A 5-word copy shows a one-beat remainder chunk, and a 4-word copy shows an exact single chunk. Narrow LEN_W = 8 and DOFF_W = 6 keep the ROMs small. A ready line that stalls one cycle in three exercises beat holding on every command kind.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

   localparam logic [3:0] OPC_READ     = 4'd1;
   localparam logic [3:0] OPC_WRITE    = 4'd2;
   localparam logic [3:0] OPC_MB_WRITE = 4'd3;
   localparam logic [3:0] OPC_STRING   = 4'd4;
   localparam logic [3:0] OPC_MB_STR   = 4'd5;
   localparam logic [3:0] OPC_ZERO     = 4'd6;
   localparam logic [3:0] OPC_UNZIP    = 4'd7;
   localparam logic [3:0] OPC_BULK     = 4'd8;

   typedef enum logic [1:0] {
      BK_READ    = 2'd0,
      BK_DIRECT  = 2'd1,
      BK_MAILBOX = 2'd2,
      BK_BULK    = 2'd3
   } bus_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_DECODE,
      ST_PREP,
      ST_BEAT,
      ST_NEXT
   } seq_state_e;

endpackage

// File: rtl/init_cmd_decode.sv
module init_cmd_decode
   import init_seq_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int DATA_W    = 32,
   parameter int DOFF_W    = 16,
   parameter int BUF_WORDS = 2048,
   localparam int CMD_W    = 4 + ADDR_W + LEN_W + DATA_W
) (
   input  logic [CMD_W-1:0]  cmd_word,
   output bus_kind_e         kind,
   output logic              from_rom,
   output logic              bulk,
   output logic              reject,
   output logic [LEN_W-1:0]  n_words,
   output logic [ADDR_W-1:0] base,
   output logic [DATA_W-1:0] imm,
   output logic [DOFF_W-1:0] doff
);

   logic [3:0]        op;
   logic [LEN_W-1:0]  len_f;
   logic [DATA_W-1:0] arg;
   logic [LEN_W-1:0]  zero_cnt;
   logic              zero_big;
   logic              copy_big;

   assign op       = cmd_word[CMD_W-1 -: 4];
   assign base     = cmd_word[DATA_W+LEN_W +: ADDR_W];
   assign len_f    = cmd_word[DATA_W +: LEN_W];
   assign arg      = cmd_word[DATA_W-1:0];
   assign doff     = arg[DOFF_W-1:0];
   assign zero_cnt = arg[LEN_W-1:0];
   assign zero_big = int'({1'b0, zero_cnt}) > BUF_WORDS;
   assign copy_big = int'({1'b0, len_f}) > BUF_WORDS;

   always_comb begin
      kind     = BK_DIRECT;
      from_rom = 1'b0;
      bulk     = 1'b0;
      reject   = 1'b0;
      n_words  = '0;
      imm      = '0;
      case (op)
         OPC_READ: begin
            kind    = BK_READ;
            n_words = LEN_W'(1);
         end
         OPC_WRITE: begin
            n_words = LEN_W'(1);
            imm     = arg;
         end
         OPC_MB_WRITE: begin
            kind    = BK_MAILBOX;
            n_words = LEN_W'(1);
            imm     = arg;
         end
         OPC_STRING: begin
            from_rom = 1'b1;
            n_words  = len_f;
         end
         OPC_MB_STR: begin
            kind     = BK_MAILBOX;
            from_rom = 1'b1;
            n_words  = len_f;
         end
         OPC_ZERO: begin
            kind    = BK_BULK;
            bulk    = 1'b1;
            n_words = zero_cnt;
            reject  = zero_big;
         end
         OPC_BULK: begin
            kind     = BK_BULK;
            bulk     = 1'b1;
            from_rom = 1'b1;
            n_words  = len_f;
            reject   = copy_big;
         end
         default: begin
            // decompress (OPC_UNZIP) and unknown codes are refused
            reject = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/init_beat_gen.sv
module init_beat_gen #(
   parameter int LEN_W     = 16,
   parameter int MAX_BURST = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_n,
   input  logic             step,
   output logic [LEN_W-1:0] word_idx,
   output logic             last_word,
   output logic             chunk_first,
   output logic             chunk_last
);

   logic [LEN_W-1:0] widx_q;
   logic [LEN_W-1:0] nreg_q;
   logic             pos_first;
   logic             pos_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         widx_q <= '0;
         nreg_q <= '0;
      end else if (load) begin
         widx_q <= '0;
         nreg_q <= load_n;
      end else if (step) begin
         widx_q <= widx_q + LEN_W'(1);
      end
   end

   assign word_idx  = widx_q;
   assign last_word = (widx_q == nreg_q - LEN_W'(1));

   generate
      if (MAX_BURST == 1) begin : g_single
         assign pos_first = 1'b1;
         assign pos_end   = 1'b1;
      end else if ((MAX_BURST & (MAX_BURST - 1)) == 0) begin : g_pow2
         localparam int PW = $clog2(MAX_BURST);
         logic [PW-1:0] pos;
         assign pos       = widx_q[PW-1:0];
         assign pos_first = (pos == '0);
         assign pos_end   = &pos;
      end else begin : g_count
         localparam int CW = $clog2(MAX_BURST);
         logic [CW-1:0] pos_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pos_q <= '0;
            else if (load)
               pos_q <= '0;
            else if (step)
               pos_q <= (pos_q == CW'(MAX_BURST - 1)) ? '0 : pos_q + CW'(1);
         end
         assign pos_first = (pos_q == '0);
         assign pos_end   = (pos_q == CW'(MAX_BURST - 1));
      end
   endgenerate

   assign chunk_first = pos_first;
   assign chunk_last  = pos_end | last_word;

endmodule

// File: rtl/init_cmd_sequencer.sv
module init_cmd_sequencer
   import init_seq_pkg::*;
#(
   parameter int IDX_W     = 8,
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int LEN_W     = 16,
   parameter int DOFF_W    = 16,
   parameter int MAX_BURST = 16,
   parameter int BUF_WORDS = 2048,
   localparam int CMD_W    = 4 + ADDR_W + LEN_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IDX_W-1:0]  first_idx,
   input  logic [IDX_W-1:0]  end_idx,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [IDX_W-1:0]  cmd_addr,
   input  logic [CMD_W-1:0]  cmd_rdata,
   output logic [DOFF_W-1:0] dat_addr,
   input  logic [DATA_W-1:0] dat_rdata,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic [1:0]        bus_kind,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_chunk_first,
   output logic              bus_chunk_last
);

   generate
      if (MAX_BURST < 1) begin : g_chk_burst
         $error("MAX_BURST must be at least 1");
      end
      if (LEN_W < 1 || LEN_W > 30) begin : g_chk_len
         $error("LEN_W must lie in 1..30");
      end
      if (MAX_BURST > (1 << LEN_W)) begin : g_chk_burst_len
         $error("MAX_BURST exceeds the largest command length");
      end
      if (DATA_W < LEN_W || DATA_W < DOFF_W) begin : g_chk_arg
         $error("DATA_W must hold both a length and a data offset");
      end
      if (BUF_WORDS < 1) begin : g_chk_buf
         $error("BUF_WORDS must be at least 1");
      end
   endgenerate

   seq_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  end_q;
   logic              err_q;
   logic              done_q;
   bus_kind_e         kind_q;
   logic              from_rom_q;
   logic              bulk_q;
   logic [ADDR_W-1:0] base_q;
   logic [DATA_W-1:0] imm_q;
   logic [DOFF_W-1:0] doff_q;

   bus_kind_e         d_kind;
   logic              d_from_rom;
   logic              d_bulk;
   logic              d_reject;
   logic [LEN_W-1:0]  d_n;
   logic [ADDR_W-1:0] d_base;
   logic [DATA_W-1:0] d_imm;
   logic [DOFF_W-1:0] d_doff;

   logic [LEN_W-1:0]  widx;
   logic              last_word;
   logic              cf;
   logic              cl;
   logic              beat_load;
   logic              beat_step;

   init_cmd_decode #(
      .ADDR_W   (ADDR_W),
      .LEN_W    (LEN_W),
      .DATA_W   (DATA_W),
      .DOFF_W   (DOFF_W),
      .BUF_WORDS(BUF_WORDS)
   ) i_decode (
      .cmd_word(cmd_rdata),
      .kind    (d_kind),
      .from_rom(d_from_rom),
      .bulk    (d_bulk),
      .reject  (d_reject),
      .n_words (d_n),
      .base    (d_base),
      .imm     (d_imm),
      .doff    (d_doff)
   );

   assign beat_load = (state_q == ST_DECODE);
   assign beat_step = (state_q == ST_BEAT) && bus_ready && !last_word;

   init_beat_gen #(
      .LEN_W    (LEN_W),
      .MAX_BURST(MAX_BURST)
   ) i_beats (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (beat_load),
      .load_n     (d_n),
      .step       (beat_step),
      .word_idx   (widx),
      .last_word  (last_word),
      .chunk_first(cf),
      .chunk_last (cl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         idx_q      <= '0;
         end_q      <= '0;
         err_q      <= 1'b0;
         done_q     <= 1'b0;
         kind_q     <= BK_DIRECT;
         from_rom_q <= 1'b0;
         bulk_q     <= 1'b0;
         base_q     <= '0;
         imm_q      <= '0;
         doff_q     <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  err_q <= 1'b0;
                  if (first_idx < end_idx) begin
                     idx_q   <= first_idx;
                     end_q   <= end_idx;
                     state_q <= ST_FETCH;
                  end else begin
                     done_q <= 1'b1;
                  end
               end
            end
            ST_FETCH: state_q <= ST_DECODE;
            ST_DECODE: begin
               kind_q     <= d_kind;
               from_rom_q <= d_from_rom;
               bulk_q     <= d_bulk;
               base_q     <= d_base;
               imm_q      <= d_imm;
               doff_q     <= d_doff;
               if (d_reject) begin
                  err_q   <= 1'b1;
                  state_q <= ST_NEXT;
               end else if (d_n == '0) begin
                  state_q <= ST_NEXT;
               end else begin
                  state_q <= ST_PREP;
               end
            end
            ST_PREP: state_q <= ST_BEAT;
            ST_BEAT: begin
               if (bus_ready)
                  state_q <= last_word ? ST_NEXT : ST_PREP;
            end
            ST_NEXT: begin
               if ((idx_q + IDX_W'(1)) == end_q) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  idx_q   <= idx_q + IDX_W'(1);
                  state_q <= ST_FETCH;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy            = (state_q != ST_IDLE);
   assign done            = done_q;
   assign err             = err_q;
   assign cmd_addr        = idx_q;
   assign dat_addr        = doff_q + DOFF_W'(widx);
   assign bus_valid       = (state_q == ST_BEAT);
   assign bus_kind        = kind_q;
   assign bus_addr        = base_q + (ADDR_W'(widx) << 2);
   assign bus_data        = from_rom_q ? dat_rdata : imm_q;
   assign bus_chunk_first = bus_valid & bulk_q & cf;
   assign bus_chunk_last  = bus_valid & bulk_q & cl;

endmodule

// File: rtl/init_cmd_sequencer_chk.sv
module init_cmd_sequencer_chk #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int MAX_BURST = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic              bus_valid,
   input logic              bus_ready,
   input logic [1:0]        bus_kind,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_data,
   input logic              bus_chunk_first,
   input logic              bus_chunk_last
);

   localparam int RW = $clog2(MAX_BURST + 1) + 1;

   logic          acc_bulk;
   logic [RW-1:0] run_q;

   assign acc_bulk = bus_valid && bus_ready && (bus_kind == 2'd3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (acc_bulk)
         run_q <= bus_chunk_first ? RW'(1) : run_q + RW'(1);
   end

   // R12
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                     $stable(bus_data) && $stable(bus_kind)));

   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   valid_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> busy);

   // R10
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> !err);

   // R7
   marker_bulk_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_kind != 2'd3) |-> (!bus_chunk_first && !bus_chunk_last));

   // R7
   chunk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_bulk && !bus_chunk_first) |-> (run_q != '0 && int'(run_q) < MAX_BURST));

endmodule

bind init_cmd_sequencer init_cmd_sequencer_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .MAX_BURST(MAX_BURST)
) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .start          (start),
   .busy           (busy),
   .done           (done),
   .err            (err),
   .bus_valid      (bus_valid),
   .bus_ready      (bus_ready),
   .bus_kind       (bus_kind),
   .bus_addr       (bus_addr),
   .bus_data       (bus_data),
   .bus_chunk_first(bus_chunk_first),
   .bus_chunk_last (bus_chunk_last)
);

// File: tb/test_init_cmd_sequencer.sv
`timescale 1ns/1ps
module test_init_cmd_sequencer;

   localparam int IW = 5;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int LW = 8;
   localparam int OW = 6;
   localparam int MB = 4;
   localparam int BW = 10;
   localparam int CW = 4 + AW + LW + DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [IW-1:0] first_idx = '0;
   logic [IW-1:0] end_idx = '0;
   logic          busy, done, err;
   logic [IW-1:0] cmd_addr;
   logic [CW-1:0] cmd_rdata;
   logic [OW-1:0] dat_addr;
   logic [DW-1:0] dat_rdata;
   logic          bus_valid;
   logic          bus_ready = 1'b0;
   logic [1:0]    bus_kind;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_data;
   logic          bus_chunk_first, bus_chunk_last;

   always #5 clk = ~clk;

   init_cmd_sequencer #(
      .IDX_W(IW), .ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .DOFF_W(OW),
      .MAX_BURST(MB), .BUF_WORDS(BW)
   ) i_init_cmd_sequencer (
      .clk(clk), .rst_n(rst_n), .start(start), .first_idx(first_idx),
      .end_idx(end_idx), .busy(busy), .done(done), .err(err),
      .cmd_addr(cmd_addr), .cmd_rdata(cmd_rdata), .dat_addr(dat_addr),
      .dat_rdata(dat_rdata), .bus_valid(bus_valid), .bus_ready(bus_ready),
      .bus_kind(bus_kind), .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_chunk_first(bus_chunk_first), .bus_chunk_last(bus_chunk_last)
   );

   // ROM models with one cycle of read latency
   logic [CW-1:0] crom [0:31];
   logic [DW-1:0] drom [0:63];
   always @(posedge clk) begin
      cmd_rdata <= crom[cmd_addr];
      dat_rdata <= drom[dat_addr];
   end

   int n_tests = 0;
   int n_fail  = 0;

   // accepted beats and expected beats
   int          log_n = 0;
   logic [1:0]  log_kind [0:63];
   logic [AW-1:0] log_addr [0:63];
   logic [DW-1:0] log_data [0:63];
   logic        log_f [0:63];
   logic        log_l [0:63];
   int          exp_n = 0;
   logic [1:0]  exp_kind [0:63];
   logic [AW-1:0] exp_addr [0:63];
   logic [DW-1:0] exp_data [0:63];
   logic        exp_f [0:63];
   logic        exp_l [0:63];

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // bus slave: ready two cycles out of three, logs accepted beats
   initial begin
      int rc = 0;
      logic stalled = 1'b0;
      logic [AW-1:0] s_addr = '0;
      logic [DW-1:0] s_data = '0;
      forever begin
         @(negedge clk);
         if (stalled) begin
            // R12: a stalled beat is still offered unchanged
            chk("R12", "held valid", bus_valid, 1);
            chk("R12", "held addr", bus_addr, s_addr);
            chk("R12", "held data", bus_data, s_data);
         end
         rc++;
         bus_ready = (rc % 3) != 0;
         #1;
         if (bus_valid && bus_ready && log_n < 64) begin
            log_kind[log_n] = bus_kind;
            log_addr[log_n] = bus_addr;
            log_data[log_n] = bus_data;
            log_f[log_n]    = bus_chunk_first;
            log_l[log_n]    = bus_chunk_last;
            log_n++;
         end
         stalled = bus_valid && !bus_ready;
         s_addr  = bus_addr;
         s_data  = bus_data;
      end
   end

   function automatic logic [CW-1:0] mk(input logic [3:0] op, input logic [AW-1:0] a,
                                        input logic [LW-1:0] l, input logic [DW-1:0] g);
      return {op, a, l, g};
   endfunction

   task automatic expect_beat(input logic [1:0] k, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input logic f, input logic l);
      exp_kind[exp_n] = k;
      exp_addr[exp_n] = a;
      exp_data[exp_n] = d;
      exp_f[exp_n]    = f;
      exp_l[exp_n]    = l;
      exp_n++;
   endtask

   // bulk beats: chunk markers from index i of n
   task automatic expect_bulk(input logic [AW-1:0] a, input int n,
                              input bit from_rom, input int off);
      for (int i = 0; i < n; i++)
         expect_beat(2'd3, a + AW'(4 * i), from_rom ? drom[off + i] : '0,
                     (i % MB) == 0, ((i % MB) == MB - 1) || (i == n - 1));
   endtask

   task automatic compare_log(input string req);
      chk(req, "beat count", log_n, exp_n);
      for (int i = 0; i < exp_n && i < log_n; i++) begin
         chk(req, $sformatf("beat %0d kind", i), log_kind[i], exp_kind[i]);
         chk(req, $sformatf("beat %0d addr", i), log_addr[i], exp_addr[i]);
         chk(req, $sformatf("beat %0d data", i), log_data[i], exp_data[i]);
         chk(req, $sformatf("beat %0d first", i), log_f[i], exp_f[i]);
         chk(req, $sformatf("beat %0d last", i), log_l[i], exp_l[i]);
      end
   endtask

   task automatic run(input int f, input int e, input bit poke);
      log_n = 0;
      exp_n = 0;
      @(negedge clk);
      first_idx = IW'(f);
      end_idx   = IW'(e);
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (f < e) chk("R11", "busy after start", busy, 1);
      chk("R10", "err cleared by start", err, 0);
      if (poke) begin
         repeat (3) @(negedge clk);
         first_idx = IW'(1);
         end_idx   = IW'(2);
         start     = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      for (int c = 0; c < 3000; c++) begin
         if (done) break;
         @(negedge clk);
      end
      chk("R11", "done seen", done, 1);
      chk("R11", "busy low with done", busy, 0);
      @(negedge clk);
      chk("R11", "done one cycle", done, 0);
   endtask

   task automatic t_reset;
      chk("R1", "busy", busy, 0);
      chk("R1", "done", done, 0);
      chk("R1", "err", err, 0);
      chk("R1", "bus_valid", bus_valid, 0);
   endtask

   task automatic t_singles;
      crom[0] = mk(4'd2, 16'h0100, 8'd5, 32'hDEAD0001);
      crom[1] = mk(4'd3, 16'h0204, 8'd0, 32'hCAFE0002);
      crom[2] = mk(4'd1, 16'h0308, 8'd3, 32'h12345678);
      run(0, 3, 0);
      expect_beat(2'd1, 16'h0100, 32'hDEAD0001, 0, 0);
      expect_beat(2'd2, 16'h0204, 32'hCAFE0002, 0, 0);
      expect_beat(2'd0, 16'h0308, 32'h0, 0, 0);
      compare_log("R3");
      chk("R3", "no error", err, 0);
   endtask

   task automatic t_strings;
      crom[0] = mk(4'd4, 16'h1000, 8'd3, 32'd5);
      crom[1] = mk(4'd5, 16'h2000, 8'd2, 32'd20);
      crom[2] = mk(4'd4, 16'h3000, 8'd0, 32'd7);
      run(0, 3, 0);
      for (int i = 0; i < 3; i++) expect_beat(2'd1, 16'h1000 + AW'(4 * i), drom[5 + i], 0, 0);
      for (int i = 0; i < 2; i++) expect_beat(2'd2, 16'h2000 + AW'(4 * i), drom[20 + i], 0, 0);
      compare_log("R4");
      chk("R4", "zero length no error", err, 0);
   endtask

   task automatic t_zero_fill;
      // length field 3 must be ignored; count 10 = limit is accepted
      crom[0] = mk(4'd6, 16'h4000, 8'd3, 32'd10);
      run(0, 1, 0);
      expect_bulk(16'h4000, 10, 0, 0);
      compare_log("R5");
      chk("R8", "limit accepted", err, 0);
   endtask

   task automatic t_bulk_copy;
      crom[0] = mk(4'd8, 16'h5000, 8'd5, 32'd30);
      crom[1] = mk(4'd8, 16'h6000, 8'd4, 32'd40);
      run(0, 2, 0);
      expect_bulk(16'h5000, 5, 1, 30);
      expect_bulk(16'h6000, 4, 1, 40);
      compare_log("R6");
      compare_log("R7");
   endtask

   task automatic t_too_big;
      crom[0] = mk(4'd8, 16'h7000, 8'd11, 32'd0);
      crom[1] = mk(4'd6, 16'h7100, 8'd2, 32'd11);
      crom[2] = mk(4'd2, 16'h7200, 8'd0, 32'h55);
      run(0, 3, 0);
      expect_beat(2'd1, 16'h7200, 32'h55, 0, 0);
      compare_log("R8");
      chk("R8", "oversize error", err, 1);
   endtask

   task automatic t_bad_ops;
      crom[0] = mk(4'd7, 16'h7300, 8'd2, 32'd1);
      crom[1] = mk(4'd0, 16'h7304, 8'd1, 32'd1);
      crom[2] = mk(4'd12, 16'h7308, 8'd1, 32'd1);
      crom[3] = mk(4'd2, 16'h7400, 8'd0, 32'h66);
      run(0, 4, 0);
      expect_beat(2'd1, 16'h7400, 32'h66, 0, 0);
      compare_log("R9");
      chk("R9", "bad op error", err, 1);
   endtask

   task automatic t_err_clear;
      repeat (5) @(negedge clk);
      chk("R10", "error sticky while idle", err, 1);
      run(3, 4, 0);
      expect_beat(2'd1, 16'h7400, 32'h66, 0, 0);
      compare_log("R10");
      chk("R10", "error clear after good run", err, 0);
   endtask

   task automatic t_range;
      for (int i = 10; i < 14; i++)
         crom[i] = mk(4'd2, AW'(16 * (i - 9)), 8'd0, DW'(i));
      run(11, 13, 0);
      expect_beat(2'd1, 16'h0020, 32'd11, 0, 0);
      expect_beat(2'd1, 16'h0030, 32'd12, 0, 0);
      compare_log("R2");
      run(5, 5, 0);
      compare_log("R2");
      run(7, 3, 0);
      compare_log("R2");
   endtask

   task automatic t_busy_start;
      crom[0] = mk(4'd6, 16'h8000, 8'd0, 32'd8);
      crom[1] = mk(4'd2, 16'h9000, 8'd0, 32'h77);
      run(0, 1, 1);
      repeat (20) @(negedge clk);
      chk("R11", "still idle after ignored start", busy, 0);
      expect_bulk(16'h8000, 8, 0, 0);
      compare_log("R11");
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) drom[i] = 32'hA5000000 + DW'(i * 32'h101);
      for (int i = 0; i < 32; i++) crom[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_singles();
      t_strings();
      t_zero_fill();
      t_bulk_copy();
      t_too_big();
      t_bad_ops();
      t_err_clear();
      t_range();
      t_busy_start();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule